// File: doc/BRIEF.md
# Parallel-Slave SPI Capture Master

This block is one read-only SPI master. It drives a single chip-select (`ssn_o`, active low) and serial clock (`sclk_o`) shared by `NCH` converters, and it shifts in all `NCH` data lines at the same time. Every frame therefore captures one word per converter on the same SCLK edges. The frame timing is set by inputs, and all of it counts system clocks:

- the SCLK half period;
- the delay from chip-select falling to the first SCLK edge;
- the delay from the last SCLK edge to chip-select rising;
- the minimum chip-select high time between samples;
- the number of samples taken per start event.

A start event is one of two things. In continuous mode the master starts itself whenever it is free. In triggered mode it waits for a trigger pulse. A trigger that arrives while a burst is running is remembered and served once the burst has ended. An availability input, held low while the converters sleep, blocks starts and discards triggers.

When a frame completes, the captured words appear on `raw_o` with a one-cycle `raw_valid_o` pulse. The words hold until the next frame completes. The output has no back-pressure: the master never stalls, and a consumer that needs the words must take them in the cycle of the pulse or read the held value before the next frame ends.

Software can drive chip-select and SCLK by hand for converter power-down sequences. The master grants this only while it is idle. A request made during a burst is deferred until the burst ends. While manual control is granted, no frame starts.

Top module: `spicap_master`

## Requirements
- R1: After a synchronous active-low reset: `ssn_o` is 1, `sclk_o` equals `cpol_i`, and `busy_o`, `raw_valid_o`, `man_active_o`, `sample_cnt_o` and `raw_o` are all 0.
- R2: During a frame, SCLK makes exactly 2·DW transitions. Successive transitions are `clk_div_i`+1 system clocks apart. SCLK does not move while chip-select is high during a burst.
- R3: The first SCLK transition comes `pre_wait_i`+1 clocks after chip-select falls.
- R4: Chip-select rises `post_wait_i`+1 clocks after the last SCLK transition.
- R5: Within a burst, chip-select stays high for max(`sample_time_i`,1) clocks between frames.
- R6: Each channel is shifted in MSB first. With `cpha_i`=0, data is sampled on SCLK transitions 1, 3, 5, …; with `cpha_i`=1, on transitions 2, 4, …. Channel c occupies `raw_o[c*DW +: DW]`. `raw_valid_o` is high for exactly one cycle per frame, and `raw_o` holds its value until the next frame completes.
- R7: A burst is `burst_len_i` frames long, and a value of 0 gives one frame. `sample_cnt_o` is cleared when a burst starts and rises by one each time chip-select rises, so it ends the burst equal to the frame count.
- R8: With `cont_mode_i`=1, bursts restart without any trigger. Triggers seen in that mode are not remembered. With `cont_mode_i`=0, no new burst starts on its own.
- R9: In triggered mode, one or more triggers that arrive during a burst cause exactly one further burst after it.
- R10: While `avail_i` is 0, no burst starts and triggers are discarded, not held.
- R11: `man_active_o` goes high one cycle after `man_req_i` is raised while idle. It is held low while the master is busy. While it is high, `ssn_o`/`sclk_o` follow `man_ssn_i`/`man_sclk_i`. A manual request blocks a start in the same cycle, and a trigger in that cycle is held and served after release.
- R12: `cpol_i` sets the SCLK level while idle, and every frame returns SCLK to that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cont_mode_i | input | 1 | 1: continuous restart, 0: triggered |
| trig_i | input | 1 | Start request pulse |
| avail_i | input | 1 | Converters awake; 0 blocks starts |
| cpol_i | input | 1 | SCLK idle level |
| cpha_i | input | 1 | 0: sample on first edge, 1: on second edge |
| clk_div_i | input | DIV_W | Clocks per SCLK half period minus one |
| pre_wait_i | input | WAIT_W | Chip-select fall to first SCLK edge, minus one |
| post_wait_i | input | WAIT_W | Last SCLK edge to chip-select rise, minus one |
| sample_time_i | input | CNT_W | Minimum chip-select high clocks between frames |
| burst_len_i | input | CNT_W | Frames per start event |
| man_req_i | input | 1 | Request manual pin control |
| man_ssn_i | input | 1 | Manual chip-select level |
| man_sclk_i | input | 1 | Manual SCLK level |
| miso_i | input | NCH | Serial data, one line per converter |
| ssn_o | output | 1 | Chip-select, active low |
| sclk_o | output | 1 | Serial clock |
| raw_o | output | NCH*DW | Captured words, channel 0 in the low bits |
| raw_valid_o | output | 1 | One-cycle pulse when `raw_o` is updated |
| busy_o | output | 1 | A burst is in progress |
| sample_cnt_o | output | CNT_W | Index of the frame in progress in the burst |
| man_active_o | output | 1 | Manual control granted |

## Verification
Two functions can compete in one cycle. A manual request and a start both want the idle master, and a trigger can land on the exact cycle in which a burst finishes. The bench raises `man_req_i` and `trig_i` on the same clock edge. It expects manual control to be granted, no frame to run while it is held, and exactly one frame to follow after release. It also pulses triggers during a running burst and expects exactly one extra burst, counted by `raw_valid_o` pulses.

// File: rtl/spicap_pkg.sv
package spicap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SHIFT,
    ST_POST,
    ST_GAP
  } spicap_state_e;
endpackage

// File: rtl/spicap_divider.sv
// Half-period tick generator for SCLK; counter is held at zero while not running.
module spicap_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spicap_shift.sv
// Parallel MSB-first shift registers with a holding register per channel.
module spicap_shift #(
  parameter int DW  = 16,
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic [NCH-1:0]    miso_i,
  input  logic              done_i,
  output logic [NCH*DW-1:0] raw_o,
  output logic              valid_o
);
  logic done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      done_q  <= done_i;
      valid_o <= done_q;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    logic [DW-1:0] sh_q;
    logic [DW-1:0] hold_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_q   <= '0;
        hold_q <= '0;
      end else begin
        if (shift_i) sh_q <= (sh_q << 1) | DW'(miso_i[ch]);
        if (done_q)  hold_q <= sh_q;
      end
    end

    assign raw_o[ch*DW +: DW] = hold_q;
  end
endmodule

// File: rtl/spicap_master.sv
module spicap_master
  import spicap_pkg::*;
#(
  parameter int DW     = 16,
  parameter int NCH    = 8,
  parameter int DIV_W  = 16,
  parameter int WAIT_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cont_mode_i,
  input  logic              trig_i,
  input  logic              avail_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [WAIT_W-1:0] pre_wait_i,
  input  logic [WAIT_W-1:0] post_wait_i,
  input  logic [CNT_W-1:0]  sample_time_i,
  input  logic [CNT_W-1:0]  burst_len_i,
  input  logic              man_req_i,
  input  logic              man_ssn_i,
  input  logic              man_sclk_i,
  input  logic [NCH-1:0]    miso_i,
  output logic              ssn_o,
  output logic              sclk_o,
  output logic [NCH*DW-1:0] raw_o,
  output logic              raw_valid_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  sample_cnt_o,
  output logic              man_active_o
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES + 1);

  spicap_state_e     state_q;
  logic [CNT_W-1:0]  wcnt_q;
  logic [CNT_W-1:0]  scnt_q;
  logic [EW-1:0]     edge_q;
  logic              ssn_q, sclk_q, pend_q, man_q;

  logic              tick, go, pre_end, last_edge, shift_en, gap_done;
  logic [CNT_W:0]    wnext;
  logic [CNT_W-1:0]  burst_lim;

  spicap_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (state_q == ST_SHIFT),
    .div_i  (clk_div_i),
    .tick_o (tick)
  );

  // Start only from idle, with converters awake and no manual request pending.
  assign go        = (state_q == ST_IDLE) && avail_i && !man_q && !man_req_i &&
                     (cont_mode_i || pend_q || trig_i);
  // The end of the pre-wait produces SCLK edge index 0; the divider produces the rest.
  assign pre_end   = (state_q == ST_PRE) && (wcnt_q == CNT_W'(pre_wait_i));
  assign last_edge = tick && (edge_q == EW'(EDGES - 1));
  assign shift_en  = (pre_end && !cpha_i) || (tick && (edge_q[0] == cpha_i));
  assign wnext     = {1'b0, wcnt_q} + (CNT_W+1)'(1);
  assign gap_done  = wnext >= {1'b0, sample_time_i};
  assign burst_lim = (burst_len_i == '0) ? CNT_W'(1) : burst_len_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      scnt_q  <= '0;
      edge_q  <= '0;
      ssn_q   <= 1'b1;
      sclk_q  <= cpol_i;
      pend_q  <= 1'b0;
      man_q   <= 1'b0;
    end else begin
      man_q <= man_req_i && (state_q == ST_IDLE);
      if (go)                                     pend_q <= 1'b0;
      else if (trig_i && avail_i && !cont_mode_i) pend_q <= 1'b1;

      unique case (state_q)
        ST_IDLE: begin
          sclk_q <= cpol_i;
          ssn_q  <= 1'b1;
          if (go) begin
            state_q <= ST_PRE;
            ssn_q   <= 1'b0;
            wcnt_q  <= '0;
            scnt_q  <= '0;
          end
        end
        ST_PRE: begin
          if (pre_end) begin
            sclk_q  <= ~sclk_q;
            edge_q  <= EW'(1);
            state_q <= ST_SHIFT;
          end else begin
            wcnt_q <= wcnt_q + CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + EW'(1);
            if (last_edge) begin
              state_q <= ST_POST;
              wcnt_q  <= '0;
            end
          end
        end
        ST_POST: begin
          if (wcnt_q == CNT_W'(post_wait_i)) begin
            ssn_q   <= 1'b1;
            scnt_q  <= scnt_q + CNT_W'(1);
            wcnt_q  <= '0;
            state_q <= ST_GAP;
          end else begin
            wcnt_q <= wcnt_q + CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (gap_done) begin
            wcnt_q <= '0;
            if (scnt_q >= burst_lim) begin
              state_q <= ST_IDLE;
            end else begin
              ssn_q   <= 1'b0;
              state_q <= ST_PRE;
            end
          end else begin
            wcnt_q <= wcnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  spicap_shift #(.DW(DW), .NCH(NCH)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift_en),
    .miso_i  (miso_i),
    .done_i  (last_edge),
    .raw_o   (raw_o),
    .valid_o (raw_valid_o)
  );

  assign busy_o       = (state_q != ST_IDLE);
  assign sample_cnt_o = scnt_q;
  assign man_active_o = man_q;
  assign ssn_o        = man_q ? man_ssn_i  : ssn_q;
  assign sclk_o       = man_q ? man_sclk_i : sclk_q;
endmodule

// File: rtl/spicap_master_chk.sv
module spicap_master_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpol_i,
  input logic [CNT_W-1:0] burst_len_i,
  input logic             ssn_o,
  input logic             sclk_o,
  input logic             raw_valid_o,
  input logic             busy_o,
  input logic             man_active_o,
  input logic [CNT_W-1:0] sample_cnt_o
);
  logic [CNT_W-1:0] lim;
  assign lim = (burst_len_i == '0) ? CNT_W'(1) : burst_len_i;

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    raw_valid_o |=> !raw_valid_o);

  p_man_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    man_active_o |-> !busy_o);

  p_idle_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o) && !man_active_o) |-> (sclk_o == $past(cpol_i)));

  p_gap_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && ssn_o && $past(ssn_o) &&
     !man_active_o && !$past(man_active_o)) |-> $stable(sclk_o));

  p_edge_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !man_active_o && !$past(man_active_o) &&
     !$stable(sclk_o)) |-> !ssn_o);

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_cnt_o != $past(sample_cnt_o)) |->
      (sample_cnt_o == $past(sample_cnt_o) + CNT_W'(1) || sample_cnt_o == '0));

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $stable(burst_len_i)) |-> (sample_cnt_o <= lim));
endmodule

bind spicap_master spicap_master_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpol_i       (cpol_i),
  .burst_len_i  (burst_len_i),
  .ssn_o        (ssn_o),
  .sclk_o       (sclk_o),
  .raw_valid_o  (raw_valid_o),
  .busy_o       (busy_o),
  .man_active_o (man_active_o),
  .sample_cnt_o (sample_cnt_o)
);

// File: tb/spicap_master_bench.sv
`timescale 1ns/1ps
module spicap_master_bench;
  localparam int DW  = 8;
  localparam int NCH = 3;
  localparam int CW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cont_mode = 1'b0, trig = 1'b0, avail = 1'b1, cpol = 1'b1, cpha = 1'b0;
  logic [15:0] clk_div = '0;
  logic [7:0]  pre_wait = '0, post_wait = '0;
  logic [CW-1:0] sample_time = '0, burst_len = 32'd1;
  logic man_req = 1'b0, man_ssn = 1'b1, man_sclk = 1'b1;
  logic [NCH-1:0] miso = '0;
  logic ssn, sclk, raw_valid, busy, man_active;
  logic [NCH*DW-1:0] raw;
  logic [CW-1:0] sample_cnt;

  always #2 clk = ~clk;

  spicap_master #(.DW(DW), .NCH(NCH), .CNT_W(CW)) u_spicap_master (
    .clk(clk), .rst_n(rst_n), .cont_mode_i(cont_mode), .trig_i(trig), .avail_i(avail),
    .cpol_i(cpol), .cpha_i(cpha), .clk_div_i(clk_div), .pre_wait_i(pre_wait),
    .post_wait_i(post_wait), .sample_time_i(sample_time), .burst_len_i(burst_len),
    .man_req_i(man_req), .man_ssn_i(man_ssn), .man_sclk_i(man_sclk), .miso_i(miso),
    .ssn_o(ssn), .sclk_o(sclk), .raw_o(raw), .raw_valid_o(raw_valid), .busy_o(busy),
    .sample_cnt_o(sample_cnt), .man_active_o(man_active)
  );

  int n_checks = 0, n_fail = 0;
  int n_vpulse = 0, n_vhigh = 0;
  logic vprev = 1'b0;
  logic [DW-1:0] word [NCH];
  int tog = 0;
  logic sprev = 1'b1;

  // Converter model and valid monitor, both evaluated away from the active edge.
  always @(negedge clk) begin
    if (raw_valid) n_vhigh++;
    if (raw_valid && !vprev) n_vpulse++;
    vprev = raw_valid;
    if (ssn) begin
      tog = 0;
    end else if (sclk != sprev) begin
      tog++;
    end
    sprev = sclk;
    for (int c = 0; c < NCH; c++) begin
      int idx;
      idx = cpha ? tog / 2 : (tog + 1) / 2;
      miso[c] = (idx < DW) ? word[c][DW-1-idx] : 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic cfg(input logic p, input logic h, input int dv, input int pr,
                     input int po, input int st, input int bl);
    @(negedge clk);
    cpol = p; cpha = h; clk_div = 16'(dv); pre_wait = 8'(pr); post_wait = 8'(po);
    sample_time = CW'(st); burst_len = CW'(bl);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic set_words(input int seed);
    for (int c = 0; c < NCH; c++) word[c] = DW'(seed * (c + 3) + c * 29 + 1);
  endtask

  // Measures one frame starting at the current negedge.
  task automatic measure(output int t_fall, output int pre_d, output int half_d,
                         output bit half_bad, output int edges, output int post_d);
    int t = 0;
    int last;
    logic prev;
    pre_d = -1; half_d = -1; half_bad = 0; edges = 0;
    while (ssn !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
    t_fall = t; last = t; prev = sclk;
    while (ssn == 1'b0 && t < t_fall + 5000) begin
      @(negedge clk); t++;
      if (sclk != prev) begin
        edges++;
        if (edges == 1) pre_d = t - t_fall;
        else if (half_d < 0) half_d = t - last;
        else if (t - last != half_d) half_bad = 1;
        last = t; prev = sclk;
      end
    end
    post_d = t - last;
  endtask

  task automatic chk_words(input string req);
    for (int c = 0; c < NCH; c++)
      chk(raw[c*DW +: DW] == word[c], req, "raw word", raw[c*DW +: DW], word[c]);
  endtask

  task automatic t_reset();
    chk(ssn == 1'b1, "R1", "ssn after reset", ssn, 1);
    chk(sclk == 1'b1, "R1", "sclk after reset", sclk, 1);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(raw_valid == 1'b0 && raw == '0, "R1", "raw/valid after reset", raw_valid, 0);
    chk(sample_cnt == '0 && man_active == 1'b0, "R1", "count/manual after reset", sample_cnt, 0);
  endtask

  task automatic t_basic();
    int tf, pd, hd, ed, po, v0, h0;
    bit hb;
    set_words(7);
    cfg(1'b1, 1'b0, 1, 2, 3, 4, 1);
    v0 = n_vpulse; h0 = n_vhigh;
    pulse_trig();
    measure(tf, pd, hd, hb, ed, po);
    chk(pd == 3, "R3", "pre delay", pd, 3);
    chk(hd == 2 && !hb, "R2", "half period", hd, 2);
    chk(ed == 2*DW, "R2", "edge count", ed, 2*DW);
    chk(po == 4, "R4", "post delay", po, 4);
    wait_idle();
    chk_words("R6");
    chk(n_vpulse - v0 == 1 && n_vhigh - h0 == 1, "R6", "valid pulse width", n_vhigh - h0, 1);
    chk(sclk == 1'b1, "R12", "sclk idle high", sclk, 1);
    chk(sample_cnt == 1, "R7", "count after single", sample_cnt, 1);
    repeat (20) @(negedge clk);
    chk_words("R6");
  endtask

  task automatic t_mode1();
    int tf, pd, hd, ed, po;
    bit hb;
    set_words(91);
    cfg(1'b0, 1'b1, 0, 0, 0, 2, 1);
    chk(sclk == 1'b0, "R12", "sclk idle low", sclk, 0);
    pulse_trig();
    measure(tf, pd, hd, hb, ed, po);
    chk(pd == 1 && hd == 1 && !hb && ed == 2*DW, "R2", "cpha1 timing", hd, 1);
    chk(po == 1, "R4", "post delay zero", po, 1);
    wait_idle();
    chk_words("R6");
    chk(sclk == 1'b0, "R12", "sclk back low", sclk, 0);
  endtask

  task automatic t_burst();
    int tf, pd, hd, ed, po, v0;
    bit hb;
    set_words(44);
    cfg(1'b1, 1'b0, 0, 1, 0, 5, 3);
    v0 = n_vpulse;
    pulse_trig();
    measure(tf, pd, hd, hb, ed, po);
    chk(sample_cnt == 1, "R7", "count mid burst", sample_cnt, 1);
    measure(tf, pd, hd, hb, ed, po);
    chk(tf == 5, "R5", "gap frame 2", tf, 5);
    measure(tf, pd, hd, hb, ed, po);
    chk(tf == 5, "R5", "gap frame 3", tf, 5);
    wait_idle();
    chk(n_vpulse - v0 == 3, "R7", "frames in burst", n_vpulse - v0, 3);
    chk(sample_cnt == 3, "R7", "count end burst", sample_cnt, 3);
    cfg(1'b1, 1'b0, 0, 1, 0, 0, 0);
    v0 = n_vpulse;
    pulse_trig();
    wait_idle();
    chk(n_vpulse - v0 == 1 && sample_cnt == 1, "R7", "zero length burst", n_vpulse - v0, 1);
    cfg(1'b1, 1'b0, 0, 1, 0, 0, 2);
    pulse_trig();
    measure(tf, pd, hd, hb, ed, po);
    measure(tf, pd, hd, hb, ed, po);
    chk(tf == 1, "R5", "gap with zero sample time", tf, 1);
    wait_idle();
  endtask

  task automatic t_pending();
    int v0;
    cfg(1'b1, 1'b0, 1, 1, 1, 2, 1);
    v0 = n_vpulse;
    pulse_trig();
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R9", "busy during frame", busy, 1);
    pulse_trig();
    pulse_trig();
    repeat (300) @(negedge clk);
    chk(n_vpulse - v0 == 2, "R9", "one extra burst", n_vpulse - v0, 2);
    chk(busy == 1'b0, "R9", "idle afterwards", busy, 0);
  endtask

  task automatic t_avail();
    int v0;
    v0 = n_vpulse;
    @(negedge clk); avail = 1'b0;
    pulse_trig();
    repeat (60) @(negedge clk);
    chk(busy == 1'b0 && n_vpulse == v0, "R10", "blocked while unavailable", n_vpulse - v0, 0);
    avail = 1'b1;
    repeat (60) @(negedge clk);
    chk(n_vpulse == v0, "R10", "trigger discarded", n_vpulse - v0, 0);
    pulse_trig();
    wait_idle();
    chk(n_vpulse - v0 == 1, "R10", "trigger after wake", n_vpulse - v0, 1);
  endtask

  task automatic t_cont();
    int v0;
    cfg(1'b1, 1'b0, 0, 0, 0, 2, 1);
    v0 = n_vpulse;
    @(negedge clk); cont_mode = 1'b1;
    repeat (300) @(negedge clk);
    chk(n_vpulse - v0 >= 3, "R8", "continuous restarts", n_vpulse - v0, 3);
    trig = 1'b1;
    @(negedge clk); trig = 1'b0; cont_mode = 1'b0;
    v0 = n_vpulse;
    repeat (150) @(negedge clk);
    chk(n_vpulse - v0 <= 1, "R8", "no held trigger from continuous", n_vpulse - v0, 1);
    v0 = n_vpulse;
    repeat (100) @(negedge clk);
    chk(n_vpulse == v0 && busy == 1'b0, "R8", "stops in triggered mode", n_vpulse - v0, 0);
  endtask

  task automatic t_manual();
    int v0;
    cfg(1'b1, 1'b0, 0, 0, 0, 1, 1);
    v0 = n_vpulse;
    @(negedge clk); man_ssn = 1'b0; man_sclk = 1'b0; man_req = 1'b1; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk(man_active == 1'b1 && busy == 1'b0, "R11", "manual wins collision", man_active, 1);
    chk(ssn == 1'b0 && sclk == 1'b0, "R11", "pins follow manual", sclk, 0);
    man_sclk = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R11", "manual sclk high", sclk, 1);
    repeat (50) @(negedge clk);
    chk(n_vpulse == v0, "R11", "no frame under manual", n_vpulse - v0, 0);
    man_ssn = 1'b1; man_req = 1'b0;
    repeat (100) @(negedge clk);
    chk(n_vpulse - v0 == 1, "R11", "held trigger served", n_vpulse - v0, 1);
    pulse_trig();
    repeat (3) @(negedge clk);
    man_req = 1'b1;
    @(negedge clk);
    chk(man_active == 1'b0 && busy == 1'b1, "R11", "no grant while busy", man_active, 0);
    repeat (100) @(negedge clk);
    chk(man_active == 1'b1 && busy == 1'b0, "R11", "grant after burst", man_active, 1);
    man_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    set_words(0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mode1();
    t_burst();
    t_pending();
    t_avail();
    t_cont();
    t_manual();
    summary();
  end
endmodule